// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide host interface of a three-channel interval timer. A two-bit address picks one of three channel data ports (0, 1, 2) or the command port (3). Command bytes program a channel's access mode, counting mode and BCD flag, snapshot a channel's count, or snapshot several channels' count and status in one go. Data-port writes are assembled into 16-bit count loads that are handed to the counting logic with a one-cycle strobe. Data-port reads return a pending status byte, a frozen count, or the live count, one byte at a time. The counting logic sits outside this block: it supplies each channel's live count and output level, and pulses a "taken" input when it has moved a new count into its counter.

Each channel holds two byte-phase machines and one snapshot machine. The write phase and the read phase each use the states PH_FIRST and PH_SECOND. In word access, each data write (or live read) moves PH_FIRST to PH_SECOND and PH_SECOND back to PH_FIRST, and a channel command forces PH_FIRST. The count snapshot machine uses the states CL_EMPTY, CL_LO, CL_HI and CL_WLO. A latch request moves CL_EMPTY to CL_LO, CL_HI or CL_WLO according to the access mode. A data read moves CL_WLO to CL_HI, and moves CL_LO or CL_HI to CL_EMPTY. A one-bit status flag is set by a status request and cleared by the next data read.

Read data is registered. The byte appears on `rdata` on the clock edge that samples `rd_en`, and it holds until the next read.

Top module: `tmr_ctrl_port`

## Requirements
- R1: A command-port write whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero programs that channel. The access mode is taken from bits 5:4 (01 low only, 10 high only, 11 low then high). The counting mode is taken from bits 3:1, with 6 and 7 folded to 2 and 3. BCD is taken from bit 0. The counting mode and BCD flag appear on `mode_sel[3c+2:3c]` and `bcd_sel[c]` after that edge.
- R2: In low-only access, a data write of byte b raises `load_stb[c]` for exactly one cycle after the write edge, with `load_val` for that channel equal to {8'h00, b}.
- R3: In high-only access, a data write of byte b produces a one-cycle load of {b, 8'h00}.
- R4: In word access, the first data byte is held and produces no load. The second data byte produces a load of {second, first}. The pair then repeats.
- R5: A channel command returns that channel's write phase and read phase to the first byte.
- R6: Live reads return the low byte in low-only access and the high byte in high-only access. In word access they alternate low, high, low, independently of the write phase.
- R7: A command with bits 5:4 = 00 freezes the channel's live count at that edge. Later data reads return the frozen low byte, the frozen high byte, or low then high, according to the access mode. Live reads then resume.
- R8: A count latch request for a channel whose frozen count is not yet fully read is ignored.
- R9: A command with bits 7:6 = 11 acts on each channel c whose bit c+1 is 1. A count latch is requested when bit 5 is 0, and a status latch is requested when bit 4 is 0. The command leaves the access mode, counting mode and BCD flag unchanged.
- R10: A status latch captures {output level, null count, access mode[1:0], counting mode[2:0], BCD} as bits 7 down to 0. A second status request is ignored while the first is unread.
- R11: A data read returns the pending status byte first, then any frozen count bytes, and only then live count bytes.
- R12: The null-count flag is set by a channel command or a data write to that channel. It is cleared by a `cnt_taken[c]` pulse, and it is 0 after reset.
- R13: A read of address 3 returns 8'h00 and changes no channel's read state.
- R14: After reset, every channel is in low-only access with counting mode 0 and BCD 0, no load strobe is active, nothing is latched, and `rdata` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | 0..2 channel data port, 3 command port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| live_cnt | input | 48 | Live 16-bit count of each channel, channel c at [16c+15:16c] |
| out_lvl | input | 3 | Output level of each channel |
| cnt_taken | input | 3 | Pulse: counting logic has taken the new count |
| load_stb | output | 3 | One-cycle count load strobe per channel |
| load_val | output | 48 | 16-bit load value per channel |
| mode_sel | output | 9 | Counting mode per channel, 3 bits each |
| bcd_sel | output | 3 | BCD flag per channel |

## Verification
Directed sequences cover the following cases:
- each access mode with byte values whose high and low halves differ, so a swapped or misplaced byte shows up;
- word-mode writes interleaved with reads, so that shared read and write phase state is exposed;
- live counts changed between a latch and its reads, which separates frozen data from live data;
- a second latch issued before the first is read, which shows whether the first value survives;
- a combined count-and-status snapshot, which pins down the read priority order.

A long constrained-random mix of commands, snapshots, data writes, reads (including address 3) and taken pulses then runs against a reference model held in the bench. This reaches phase and latch combinations that the directed cases do not.

// File: rtl/tmr_if_pkg.sv
`timescale 1ns/1ps
package tmr_if_pkg;
    localparam int NCH = 3;
    localparam int BW  = 8;
    localparam int CW  = 2 * BW;
    localparam int MW  = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        CL_EMPTY = 2'd0,
        CL_LO    = 2'd1,
        CL_HI    = 2'd2,
        CL_WLO   = 2'd3
    } clat_e;

    function automatic logic [MW-1:0] fold_mode(input logic [MW-1:0] m);
        return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
    endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
`timescale 1ns/1ps
module tmr_cmd_decode
    import tmr_if_pkg::*;
(
    input  logic           wr_en,
    input  logic [1:0]     addr,
    input  logic [BW-1:0]  wdata,
    output logic [NCH-1:0] prog_stb,
    output logic [NCH-1:0] lat_cnt_stb,
    output logic [NCH-1:0] lat_sts_stb,
    output logic [NCH-1:0] data_wr_stb
);
    logic cmd_wr;
    logic is_rback;

    assign cmd_wr   = wr_en && (addr == 2'd3);
    assign is_rback = (wdata[7:6] == 2'd3);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = (wdata[7:6] == 2'(c));
        assign data_wr_stb[c] = wr_en && (addr == 2'(c));
        assign prog_stb[c]    = cmd_wr && hit && (wdata[5:4] != 2'b00);
        assign lat_cnt_stb[c] = cmd_wr && ((hit && (wdata[5:4] == 2'b00)) ||
                                           (is_rback && wdata[c+1] && !wdata[5]));
        assign lat_sts_stb[c] = cmd_wr && is_rback && wdata[c+1] && !wdata[4];
    end
endmodule

// File: rtl/tmr_chan_port.sv
`timescale 1ns/1ps
module tmr_chan_port
    import tmr_if_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_stb,
    input  logic [BW-1:0] ctl_byte,
    input  logic          lat_cnt_stb,
    input  logic          lat_sts_stb,
    input  logic          data_wr_stb,
    input  logic          data_rd_stb,
    input  logic [BW-1:0] wbyte,
    input  logic [CW-1:0] live_cnt,
    input  logic          out_lvl,
    input  logic          cnt_taken,
    output logic [BW-1:0] rd_byte,
    output logic          load_stb,
    output logic [CW-1:0] load_val,
    output logic [MW-1:0] mode,
    output logic          bcd
);
    acc_e          acc_q,  acc_d;
    logic [MW-1:0] mode_q, mode_d;
    logic          bcd_q,  bcd_d;
    phase_e        wph_q,  wph_d;
    phase_e        rph_q,  rph_d;
    logic [BW-1:0] hold_q, hold_d;
    clat_e         cl_q,   cl_d;
    logic [CW-1:0] clv_q,  clv_d;
    logic          sp_q,   sp_d;
    logic [BW-1:0] sv_q,   sv_d;
    logic          null_q, null_d;
    logic          lstb_q, lstb_d;
    logic [CW-1:0] lval_q, lval_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= ACC_LO;
            mode_q <= '0;
            bcd_q  <= 1'b0;
            wph_q  <= PH_FIRST;
            rph_q  <= PH_FIRST;
            hold_q <= '0;
            cl_q   <= CL_EMPTY;
            clv_q  <= '0;
            sp_q   <= 1'b0;
            sv_q   <= '0;
            null_q <= 1'b0;
            lstb_q <= 1'b0;
            lval_q <= '0;
        end else begin
            acc_q  <= acc_d;
            mode_q <= mode_d;
            bcd_q  <= bcd_d;
            wph_q  <= wph_d;
            rph_q  <= rph_d;
            hold_q <= hold_d;
            cl_q   <= cl_d;
            clv_q  <= clv_d;
            sp_q   <= sp_d;
            sv_q   <= sv_d;
            null_q <= null_d;
            lstb_q <= lstb_d;
            lval_q <= lval_d;
        end
    end

    // next-state logic
    always_comb begin
        acc_d  = acc_q;
        mode_d = mode_q;
        bcd_d  = bcd_q;
        wph_d  = wph_q;
        rph_d  = rph_q;
        hold_d = hold_q;
        cl_d   = cl_q;
        clv_d  = clv_q;
        sp_d   = sp_q;
        sv_d   = sv_q;
        null_d = null_q;
        lstb_d = 1'b0;
        lval_d = lval_q;

        // read sequencer: status, then frozen count, then live phase
        if (data_rd_stb) begin
            if (sp_q) begin
                sp_d = 1'b0;
            end else if (cl_q != CL_EMPTY) begin
                unique case (cl_q)
                    CL_WLO:       cl_d = CL_HI;
                    CL_LO, CL_HI: cl_d = CL_EMPTY;
                    CL_EMPTY:     cl_d = CL_EMPTY;
                endcase
            end else if (acc_q == ACC_WORD) begin
                rph_d = (rph_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
            end
        end

        // write sequencer
        if (prog_stb) begin
            acc_d  = acc_e'(ctl_byte[5:4]);
            mode_d = fold_mode(ctl_byte[3:1]);
            bcd_d  = ctl_byte[0];
            wph_d  = PH_FIRST;
            rph_d  = PH_FIRST;
        end else if (data_wr_stb) begin
            unique case (acc_q)
                ACC_LO: begin
                    lstb_d = 1'b1;
                    lval_d = {{BW{1'b0}}, wbyte};
                end
                ACC_HI: begin
                    lstb_d = 1'b1;
                    lval_d = {wbyte, {BW{1'b0}}};
                end
                ACC_WORD: begin
                    unique case (wph_q)
                        PH_FIRST: begin
                            hold_d = wbyte;
                            wph_d  = PH_SECOND;
                        end
                        PH_SECOND: begin
                            lstb_d = 1'b1;
                            lval_d = {wbyte, hold_q};
                            wph_d  = PH_FIRST;
                        end
                    endcase
                end
                ACC_LATCH: ;
            endcase
        end

        // snapshot requests, ignored while an earlier one is unread
        if (lat_cnt_stb && (cl_q == CL_EMPTY)) begin
            clv_d = live_cnt;
            unique case (acc_q)
                ACC_HI:            cl_d = CL_HI;
                ACC_WORD:          cl_d = CL_WLO;
                ACC_LO, ACC_LATCH: cl_d = CL_LO;
            endcase
        end
        if (lat_sts_stb && !sp_q) begin
            sp_d = 1'b1;
            sv_d = {out_lvl, null_q, acc_q, mode_q, bcd_q};
        end

        if (prog_stb || data_wr_stb) begin
            null_d = 1'b1;
        end else if (cnt_taken) begin
            null_d = 1'b0;
        end
    end

    // output logic
    always_comb begin
        rd_byte = live_cnt[BW-1:0];
        if (sp_q) begin
            rd_byte = sv_q;
        end else begin
            unique case (cl_q)
                CL_LO, CL_WLO: rd_byte = clv_q[BW-1:0];
                CL_HI:         rd_byte = clv_q[CW-1:BW];
                CL_EMPTY: begin
                    unique case (acc_q)
                        ACC_HI:   rd_byte = live_cnt[CW-1:BW];
                        ACC_WORD: rd_byte = (rph_q == PH_FIRST) ? live_cnt[BW-1:0]
                                                                : live_cnt[CW-1:BW];
                        ACC_LO, ACC_LATCH: rd_byte = live_cnt[BW-1:0];
                    endcase
                end
            endcase
        end
    end

    assign load_stb = lstb_q;
    assign load_val = lval_q;
    assign mode     = mode_q;
    assign bcd      = bcd_q;

    // R2: a load strobe only follows a data write
    a_r2_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        lstb_q |-> $past(data_wr_stb));
    // R4: the first byte of a word write produces no load
    a_r4_first_byte_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_stb && !prog_stb && acc_q == ACC_WORD && wph_q == PH_FIRST) |=> !lstb_q);
    // R5: a channel command restarts both byte phases
    a_r5_prog_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |=> (wph_q == PH_FIRST && rph_q == PH_FIRST));
    // R8: a frozen count is not overwritten until read
    a_r8_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_q != CL_EMPTY && !data_rd_stb) |=> $stable(clv_q));
    // R10: a pending status byte is kept until read
    a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q && !data_rd_stb) |=> (sp_q && $stable(sv_q)));
    // R11: a read that returns status leaves the frozen count untouched
    a_r11_status_first: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_stb && sp_q && !lat_cnt_stb) |=> $stable(cl_q));
    // R12: programming or writing marks the count as not yet taken
    a_r12_null_set: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb || data_wr_stb) |=> null_q);
endmodule

// File: rtl/tmr_ctrl_port.sv
`timescale 1ns/1ps
module tmr_ctrl_port
    import tmr_if_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [BW-1:0]      wdata,
    output logic [BW-1:0]      rdata,
    input  logic [NCH*CW-1:0]  live_cnt,
    input  logic [NCH-1:0]     out_lvl,
    input  logic [NCH-1:0]     cnt_taken,
    output logic [NCH-1:0]     load_stb,
    output logic [NCH*CW-1:0]  load_val,
    output logic [NCH*MW-1:0]  mode_sel,
    output logic [NCH-1:0]     bcd_sel
);
    logic [NCH-1:0] prog_stb;
    logic [NCH-1:0] lat_cnt_stb;
    logic [NCH-1:0] lat_sts_stb;
    logic [NCH-1:0] data_wr_stb;
    logic [NCH-1:0] data_rd_stb;
    logic [BW-1:0]  rd_bytes [NCH];
    logic [BW-1:0]  sel_byte;
    logic [BW-1:0]  rdata_q;

    tmr_cmd_decode u_dec (
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .prog_stb    (prog_stb),
        .lat_cnt_stb (lat_cnt_stb),
        .lat_sts_stb (lat_sts_stb),
        .data_wr_stb (data_wr_stb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign data_rd_stb[c] = rd_en && (addr == 2'(c));
        tmr_chan_port u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .prog_stb    (prog_stb[c]),
            .ctl_byte    (wdata),
            .lat_cnt_stb (lat_cnt_stb[c]),
            .lat_sts_stb (lat_sts_stb[c]),
            .data_wr_stb (data_wr_stb[c]),
            .data_rd_stb (data_rd_stb[c]),
            .wbyte       (wdata),
            .live_cnt    (live_cnt[c*CW +: CW]),
            .out_lvl     (out_lvl[c]),
            .cnt_taken   (cnt_taken[c]),
            .rd_byte     (rd_bytes[c]),
            .load_stb    (load_stb[c]),
            .load_val    (load_val[c*CW +: CW]),
            .mode        (mode_sel[c*MW +: MW]),
            .bcd         (bcd_sel[c])
        );
    end

    always_comb begin
        sel_byte = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == 2'(c)) sel_byte = rd_bytes[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= sel_byte;
        end
    end

    assign rdata = rdata_q;

    // R13: the command port reads as zero
    a_r13_cmd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=> (rdata == '0));
    // R14: read data only changes on a read
    a_r14_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/tmr_ctrl_port_tb.sv
`timescale 1ns/1ps
module tmr_ctrl_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt;
    logic [2:0]  out_lvl = '0;
    logic [2:0]  cnt_taken = '0;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  mode_sel;
    logic [2:0]  bcd_sel;

    logic [15:0] live [3];
    assign live_cnt = {live[2], live[1], live[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_ctrl_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .out_lvl(out_lvl),
        .cnt_taken(cnt_taken), .load_stb(load_stb), .load_val(load_val),
        .mode_sel(mode_sel), .bcd_sel(bcd_sel)
    );

    int total = 0, fails = 0;
    bit done = 0;

    // reference model state
    int m_acc[3], m_mode[3], m_bcd[3], m_wph[3], m_rph[3], m_hold[3];
    int m_cl[3], m_clv[3], m_sp[3], m_sv[3], m_null[3];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 1; m_mode[c] = 0; m_bcd[c] = 0; m_wph[c] = 0; m_rph[c] = 0;
            m_hold[c] = 0; m_cl[c] = 0; m_clv[c] = 0; m_sp[c] = 0; m_sv[c] = 0; m_null[c] = 0;
        end
    endtask

    task automatic m_lat_cnt(input int c);
        if (m_cl[c] == 0) begin
            m_clv[c] = int'(live[c]);
            m_cl[c] = (m_acc[c] == 2) ? 2 : (m_acc[c] == 3) ? 3 : 1;
        end
    endtask

    task automatic m_lat_sts(input int c);
        if (m_sp[c] == 0) begin
            m_sp[c] = 1;
            m_sv[c] = (int'(out_lvl[c]) << 7) | (m_null[c] << 6) | (m_acc[c] << 4) |
                      (m_mode[c] << 1) | m_bcd[c];
        end
    endtask

    task automatic m_cmd(input logic [7:0] d);
        int s;
        s = int'(d[7:6]);
        if (s == 3) begin
            for (int c = 0; c < 3; c++) begin
                if (d[c+1]) begin
                    if (!d[5]) m_lat_cnt(c);
                    if (!d[4]) m_lat_sts(c);
                end
            end
        end else if (d[5:4] == 2'b00) begin
            m_lat_cnt(s);
        end else begin
            m_acc[s] = int'(d[5:4]);
            m_mode[s] = int'(d[3:1]);
            if (m_mode[s] > 5) m_mode[s] -= 4;
            m_bcd[s] = int'(d[0]);
            m_wph[s] = 0; m_rph[s] = 0; m_null[s] = 1;
        end
    endtask

    task automatic m_data(input int c, input int d, output int stb, output int val);
        stb = 0; val = 0; m_null[c] = 1;
        case (m_acc[c])
            1: begin stb = 1; val = d; end
            2: begin stb = 1; val = d << 8; end
            default: begin
                if (m_wph[c] == 0) begin m_hold[c] = d; m_wph[c] = 1; end
                else begin stb = 1; val = (d << 8) | m_hold[c]; m_wph[c] = 0; end
            end
        endcase
    endtask

    task automatic m_read(input int a, output int e);
        int lv;
        if (a == 3) begin e = 0; return; end
        lv = int'(live[a]);
        if (m_sp[a] != 0) begin
            e = m_sv[a]; m_sp[a] = 0;
        end else if (m_cl[a] != 0) begin
            case (m_cl[a])
                1: begin e = m_clv[a] & 8'hFF; m_cl[a] = 0; end
                2: begin e = m_clv[a] >> 8; m_cl[a] = 0; end
                default: begin e = m_clv[a] & 8'hFF; m_cl[a] = 2; end
            endcase
        end else begin
            case (m_acc[a])
                2: e = lv >> 8;
                3: begin
                    e = (m_rph[a] == 0) ? (lv & 8'hFF) : (lv >> 8);
                    m_rph[a] = 1 - m_rph[a];
                end
                default: e = lv & 8'hFF;
            endcase
        end
    endtask

    // bus tasks: entered and left at a falling edge
    task automatic wr(input int a, input logic [7:0] d, input string tag);
        int stb, val, c;
        wr_en = 1'b1; addr = 2'(a); wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (a == 3) begin
            m_cmd(d);
            chk({tag, " R2 no load on command"}, int'(load_stb), 0);
            for (c = 0; c < 3; c++) begin
                chk({tag, " R1 mode"}, int'(mode_sel[3*c +: 3]), m_mode[c]);
                chk({tag, " R1 bcd"}, int'(bcd_sel[c]), m_bcd[c]);
            end
        end else begin
            m_data(a, int'(d), stb, val);
            chk({tag, " R2/R3/R4 load strobe"}, int'(load_stb), stb << a);
            if (stb != 0) chk({tag, " R2/R3/R4 load value"}, int'(load_val[16*a +: 16]), val);
        end
    endtask

    task automatic rd(input int a, input string tag);
        int e;
        rd_en = 1'b1; addr = 2'(a);
        m_read(a, e);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " read byte"}, int'(rdata), e);
    endtask

    task automatic taken(input int c);
        cnt_taken = 3'(1 << c);
        @(posedge clk); @(negedge clk);
        cnt_taken = '0;
        m_null[c] = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL R14 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++) live[c] = 16'h0000;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R14 reset state
        chk("R14 rdata", int'(rdata), 0);
        chk("R14 load_stb", int'(load_stb), 0);
        chk("R14 mode_sel", int'(mode_sel), 0);
        chk("R14 bcd_sel", int'(bcd_sel), 0);
        live[0] = 16'hA55A;
        rd(0, "R14 low-only after reset");

        // R1 decode and mode folding
        wr(3, 8'h3D, "R1 ch0 word mode6 bcd");
        chk("R1 mode fold 6->2", int'(mode_sel[2:0]), 2);
        wr(3, 8'h7E, "R1 ch1 word mode7");
        chk("R1 mode fold 7->3", int'(mode_sel[5:3]), 3);

        // R4 word write
        wr(0, 8'h34, "R4 first byte");
        wr(0, 8'h12, "R4 second byte");
        chk("R4 load 1234", int'(load_val[15:0]), 16'h1234);

        // R2 / R3
        wr(3, 8'h50, "R2 ch1 low-only");
        wr(1, 8'hAB, "R2 low write");
        chk("R2 load 00AB", int'(load_val[31:16]), 16'h00AB);
        wr(3, 8'hA0, "R3 ch2 high-only");
        wr(2, 8'hCD, "R3 high write");
        chk("R3 load CD00", int'(load_val[47:32]), 16'hCD00);

        // R6 live reads, word alternation independent of write phase
        live[0] = 16'hBEEF;
        rd(0, "R6 word low"); rd(0, "R6 word high");
        wr(0, 8'h77, "R6 write phase moves");
        rd(0, "R6 word low again");
        live[2] = 16'h4321;
        rd(2, "R6 high-only");

        // R5 command resets phases
        wr(3, 8'h30, "R5 reprogram ch0");
        wr(0, 8'h11, "R5 first");
        wr(0, 8'h22, "R5 second");
        chk("R5 load 2211", int'(load_val[15:0]), 16'h2211);
        rd(0, "R5 read low first");

        // R7 counter latch
        rd(0, "R7 align");
        live[0] = 16'h1357;
        wr(3, 8'h00, "R7 latch ch0");
        live[0] = 16'h9999;
        rd(0, "R7 frozen low"); rd(0, "R7 frozen high"); rd(0, "R7 live resumes");

        // R8 second latch ignored
        rd(0, "R8 align");
        live[0] = 16'h2468;
        wr(3, 8'h00, "R8 first latch");
        live[0] = 16'hFFFF;
        wr(3, 8'h00, "R8 second latch ignored");
        rd(0, "R8 low"); rd(0, "R8 high");

        // R9 / R10 status read-back
        out_lvl = 3'b001;
        wr(3, 8'hE2, "R9 status only ch0");
        out_lvl = 3'b000;
        wr(3, 8'hE2, "R10 second status ignored");
        rd(0, "R10 status byte");
        chk("R9 mode kept", int'(mode_sel[2:0]), 0);

        // R11 combined snapshot priority
        live[0] = 16'h5A3C;
        wr(3, 8'hC2, "R11 count+status ch0");
        live[0] = 16'h0F0F;
        rd(0, "R11 status first"); rd(0, "R11 count low");
        rd(0, "R11 count high"); rd(0, "R11 live after");

        // R12 null count
        taken(0);
        wr(3, 8'hE2, "R12 status after taken");
        rd(0, "R12 null cleared");
        wr(0, 8'h01, "R12 write sets null");
        wr(3, 8'hE2, "R12 status after write");
        rd(0, "R12 null set");

        // R13 command port read
        rd(0, "R13 pre");
        rd(3, "R13 cmd port zero");
        rd(0, "R13 phase unchanged");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int op, c;
            logic [7:0] b;
            for (int k = 0; k < 3; k++) live[k] = 16'($urandom);
            out_lvl = 3'($urandom);
            op = $urandom_range(0, 99);
            c  = $urandom_range(0, 2);
            b  = 8'($urandom);
            if (op < 25) begin
                b[7:6] = 2'(c);
                wr(3, b, "R1/R7 random command");
            end else if (op < 35) begin
                b[7:6] = 2'b11;
                wr(3, b, "R9/R10 random read-back");
            end else if (op < 65) begin
                wr(c, b, "R2/R3/R4 random data");
            end else if (op < 95) begin
                rd($urandom_range(0, 3), "R6/R11/R13 random read");
            end else begin
                taken(c);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule